// File: doc/BRIEF.md
# Framebuffer scan-out address generator

This block turns a stream of pixel strobes from a separate display timing generator into word reads of an external frame memory. It then turns the returned 32-bit words into 8-bit red, green and blue values with a data-enable. It serves one fixed mode: 640 visible pixels on each of 480 lines, in 24-bit true colour, with one memory word per pixel. Each line of the frame takes 1024 consecutive words. Only the first 640 words of a line are ever read.

Software programs the block through a two-word register port. Word index 0 holds the frame base, of which only the top 11 bits are kept, so the frame always starts on a 2 MiB byte boundary. Word index 1 is control: bit 0 turns the display on and bit 1 selects a 180-degree rotated scan. The frame strobe samples the base and rotation, so a frame never mixes two settings. The block keeps one read in flight ahead of the pixel it is about to show. When a word arrives too late, the block shows black for that pixel and raises a sticky underrun flag.

The visible size, the line stride and the number of retained base bits are parameters. Their defaults give the mode described above.

Top module: `fbs_scan_top`

## Requirements
- R1: After reset, mem_req, pix_de, pix_r/g/b and underrun are 0, and both registers read back 0.
- R2: A write with reg_sel=0 stores the top BASE_BITS bits of reg_wdata (bits 31:21 by default). Reading with reg_sel=0 returns those bits in place with all lower bits 0. A write with reg_sel=1 stores bit 0 (enable) and bit 1 (rotate). Reading it returns them in bits 1:0 with bits 31:2 zero.
- R3: With rotation off, pixel k of a frame (row y=k/H_VIS, column x=k%H_VIS, raster order) is requested at word address (base>>2) + y*2^STRIDE_LOG2 + x. No column at or above H_VIS is ever requested.
- R4: With rotation on, pixel k is requested at (base>>2) + (V_VIS-1-y)*2^STRIDE_LOG2 + (H_VIS-1-x).
- R5: A shown pixel drives pix_r=word[23:16], pix_g=word[15:8] and pix_b=word[7:0]. Word bits 31:24 have no effect.
- R6: While the enable bit is 0, mem_req and pix_de stay 0 and the colour outputs are 0. Clearing enable mid-frame ends the frame, and only a new frame strobe with enable set restarts scan-out.
- R7: Base or rotation writes made during a frame do not change that frame's addresses. The next frame strobe applies them.
- R8: A frame strobe sampled with enable set issues the request for pixel 0 one cycle later. A pixel strobe for pixel k sets pix_de one cycle later with that pixel's colour, and in the same cycle issues the request for pixel k+1 if one remains.
- R9: If the word for a pixel has not returned by the cycle in which its strobe is sampled, that pixel is shown as black with pix_de set, and underrun goes to 1 and stays 1 until reset. The late word is dropped and does not shift any later pixel.
- R10: After H_VIS*V_VIS pixels have been shown, further pixel strobes give no pix_de and no request until the next frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register word index: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tg_frame | input | 1 | Frame start strobe from the timing generator |
| tg_pixel | input | 1 | Strobe: next visible pixel is due |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 30 | Word address of the read |
| rd_valid | input | 1 | Read data valid, returned in request order |
| rd_data | input | 32 | Read data word |
| pix_de | output | 1 | Pixel data enable |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |
| underrun | output | 1 | Sticky late-data flag |

## Verification
The hardest state to reach from the ports is a read that is still in flight and must be thrown away. This happens when a pixel falls due before its word returns, or when enable is cleared while a read is outstanding. The in-order memory model in the bench can give one chosen address a long latency. That holds back every later reply behind it, so two pixels in a row underrun and then timing recovers, and the stale words arrive while fresh reads are pending. A separate frame clears enable just after a request has gone out, and the next frame must then show its first pixels from the fresh data rather than from the dropped word.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   localparam int REG_W   = 32;
   localparam int MADDR_W = REG_W - 2;
   localparam int COMP_W  = 8;

   typedef struct packed {
      logic [COMP_W-1:0] r;
      logic [COMP_W-1:0] g;
      logic [COMP_W-1:0] b;
   } rgb_t;
endpackage

// File: rtl/fbs_regs.sv
module fbs_regs
   import fbs_pkg::*;
#(
   parameter int BASE_BITS = 11
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we,
   input  logic                 sel,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic [BASE_BITS-1:0] base_o,
   output logic                 en_o,
   output logic                 rot_o
);
   localparam int LOW_W = REG_W - BASE_BITS;

   logic unused_wd;
   assign unused_wd = ^wdata[LOW_W-1:2];

   always_ff @(posedge clk) begin
      if (rst) begin
         base_o <= '0;
         en_o   <= 1'b0;
         rot_o  <= 1'b0;
      end else if (we) begin
         if (sel) begin
            en_o  <= wdata[0];
            rot_o <= wdata[1];
         end else begin
            base_o <= wdata[REG_W-1 -: BASE_BITS];
         end
      end
   end

   always_comb begin
      if (sel) rdata = {{(REG_W-2){1'b0}}, rot_o, en_o};
      else     rdata = {base_o, {LOW_W{1'b0}}};
   end
endmodule

// File: rtl/fbs_addr_map.sv
module fbs_addr_map
   import fbs_pkg::*;
#(
   parameter int H_VIS       = 640,
   parameter int V_VIS       = 480,
   parameter int STRIDE_LOG2 = 10,
   parameter int BASE_BITS   = 11,
   parameter bit ROT_EN      = 1'b1,
   localparam int X_W = (H_VIS > 1) ? $clog2(H_VIS) : 1,
   localparam int Y_W = (V_VIS > 1) ? $clog2(V_VIS) : 1
) (
   input  logic [X_W-1:0]       x,
   input  logic [Y_W-1:0]       y,
   input  logic                 rot,
   input  logic [BASE_BITS-1:0] base,
   output logic [MADDR_W-1:0]   addr
);
   logic [MADDR_W-1:0] row_w, col_w, base_w;

   generate
      if (ROT_EN) begin : g_rot
         assign row_w = rot ? (MADDR_W'(V_VIS - 1) - MADDR_W'(y)) : MADDR_W'(y);
         assign col_w = rot ? (MADDR_W'(H_VIS - 1) - MADDR_W'(x)) : MADDR_W'(x);
      end else begin : g_fwd
         logic unused_rot;
         assign unused_rot = rot;
         assign row_w = MADDR_W'(y);
         assign col_w = MADDR_W'(x);
      end
   endgenerate

   assign base_w = MADDR_W'(base) << (MADDR_W - BASE_BITS);
   assign addr   = base_w + (row_w << STRIDE_LOG2) + col_w;
endmodule

// File: rtl/fbs_unpack.sv
module fbs_unpack
   import fbs_pkg::*;
(
   input  logic [REG_W-1:0] word,
   output rgb_t             px
);
   logic unused_hi;
   assign unused_hi = ^word[REG_W-1:3*COMP_W];

   generate
      for (genvar c = 0; c < 3; c++) begin : g_comp
         logic [COMP_W-1:0] lvl;
         assign lvl = word[c*COMP_W +: COMP_W];
      end
   endgenerate

   assign px.b = g_comp[0].lvl;
   assign px.g = g_comp[1].lvl;
   assign px.r = g_comp[2].lvl;
endmodule

// File: rtl/fbs_scan_top.sv
module fbs_scan_top
   import fbs_pkg::*;
#(
   parameter int H_VIS       = 640,
   parameter int V_VIS       = 480,
   parameter int STRIDE_LOG2 = 10,
   parameter int BASE_BITS   = 11,
   parameter int STALE_W     = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_we,
   input  logic               reg_sel,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               tg_frame,
   input  logic               tg_pixel,
   output logic               mem_req,
   output logic [MADDR_W-1:0] mem_addr,
   input  logic               rd_valid,
   input  logic [REG_W-1:0]   rd_data,
   output logic               pix_de,
   output logic [COMP_W-1:0]  pix_r,
   output logic [COMP_W-1:0]  pix_g,
   output logic [COMP_W-1:0]  pix_b,
   output logic               underrun
);
   localparam int X_W = (H_VIS > 1) ? $clog2(H_VIS) : 1;
   localparam int Y_W = (V_VIS > 1) ? $clog2(V_VIS) : 1;

   generate
      if (H_VIS > (1 << STRIDE_LOG2)) begin : g_bad_stride
         $error("visible width exceeds line stride");
      end
      if (BASE_BITS < 1 || BASE_BITS > REG_W - 3) begin : g_bad_base
         $error("base width out of range");
      end
      if ((Y_W + STRIDE_LOG2) > (MADDR_W - BASE_BITS)) begin : g_bad_frame
         $error("frame does not fit below the base boundary");
      end
   endgenerate

   logic [BASE_BITS-1:0] cfg_base, sh_base, m_base;
   logic                 cfg_en, cfg_rot, sh_rot, m_rot;
   logic                 frame_run, run, start, flush, strobe;
   logic [X_W-1:0]       nx, mx, nx_n;
   logic [Y_W-1:0]       ny, my, ny_n;
   logic                 last_iss, last_n, at_eol, issue_next;
   logic                 outst, buf_ok, have, good_ret, drop;
   logic                 stale_inc;
   logic [REG_W-1:0]     buf_q, pix_word;
   logic [STALE_W-1:0]   stale_q;
   logic [MADDR_W-1:0]   map_addr;
   rgb_t                 up_px;

   fbs_regs #(.BASE_BITS(BASE_BITS)) u_regs (
      .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .rdata(reg_rdata), .base_o(cfg_base), .en_o(cfg_en), .rot_o(cfg_rot)
   );

   assign start      = tg_frame & cfg_en;
   assign flush      = tg_frame | ~cfg_en;
   assign run        = frame_run & cfg_en;
   assign strobe     = tg_pixel & run & ~tg_frame;
   assign issue_next = strobe & ~last_iss;
   assign good_ret   = rd_valid & (stale_q == '0);
   assign drop       = rd_valid & (stale_q != '0);
   assign have       = buf_ok | good_ret;
   assign pix_word   = buf_ok ? buf_q : rd_data;
   assign stale_inc  = (flush & outst & ~good_ret) | (strobe & ~have & outst);

   assign mx     = start ? '0 : nx;
   assign my     = start ? '0 : ny;
   assign m_rot  = start ? cfg_rot : sh_rot;
   assign m_base = start ? cfg_base : sh_base;
   assign at_eol = (mx == X_W'(H_VIS - 1));
   assign nx_n   = at_eol ? '0 : mx + X_W'(1);
   assign ny_n   = at_eol ? my + Y_W'(1) : my;
   assign last_n = at_eol & (my == Y_W'(V_VIS - 1));

   fbs_addr_map #(
      .H_VIS(H_VIS), .V_VIS(V_VIS), .STRIDE_LOG2(STRIDE_LOG2),
      .BASE_BITS(BASE_BITS), .ROT_EN(1'b1)
   ) u_map (
      .x(mx), .y(my), .rot(m_rot), .base(m_base), .addr(map_addr)
   );

   fbs_unpack u_unpack (.word(pix_word), .px(up_px));

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_base   <= '0;
         sh_rot    <= 1'b0;
         frame_run <= 1'b0;
         nx        <= '0;
         ny        <= '0;
         last_iss  <= 1'b0;
         outst     <= 1'b0;
         buf_ok    <= 1'b0;
         buf_q     <= '0;
         stale_q   <= '0;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         pix_de    <= 1'b0;
         pix_r     <= '0;
         pix_g     <= '0;
         pix_b     <= '0;
         underrun  <= 1'b0;
      end else begin
         stale_q <= stale_q + STALE_W'(stale_inc) - STALE_W'(drop);
         mem_req <= start | issue_next;
         if (start | issue_next) begin
            mem_addr <= map_addr;
            nx       <= nx_n;
            ny       <= ny_n;
            last_iss <= last_n;
         end
         if (start) begin
            sh_base <= cfg_base;
            sh_rot  <= cfg_rot;
         end
         pix_de <= strobe;
         pix_r  <= (strobe & have) ? up_px.r : '0;
         pix_g  <= (strobe & have) ? up_px.g : '0;
         pix_b  <= (strobe & have) ? up_px.b : '0;
         if (strobe & ~have) underrun <= 1'b1;
         if (flush) begin
            buf_ok    <= 1'b0;
            outst     <= start;
            frame_run <= start;
         end else if (strobe) begin
            buf_ok <= 1'b0;
            outst  <= issue_next;
            if (last_iss) frame_run <= 1'b0;
         end else if (good_ret) begin
            buf_ok <= 1'b1;
            buf_q  <= rd_data;
            outst  <= 1'b0;
         end
      end
   end

   // R6
   no_req_off_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> !mem_req);
   // R6
   black_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !pix_de |-> (pix_r == '0 && pix_g == '0 && pix_b == '0));
   // R8
   de_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      pix_de |-> $past(tg_pixel));
   // R9
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      underrun |=> underrun);
   // R9
   stale_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (stale_q == '1) |-> !stale_inc);
   // R3
   col_visible_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> (32'(mem_addr[STRIDE_LOG2-1:0]) < H_VIS));
endmodule

// File: tb/fbs_scan_top_bench.sv
module fbs_scan_top_bench;
   localparam int H  = 8;
   localparam int V  = 4;
   localparam int SL = 4;
   localparam int N  = H * V;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        tg_frame = 1'b0, tg_pixel = 1'b0;
   logic        mem_req, rd_valid = 1'b0;
   logic [29:0] mem_addr;
   logic [31:0] rd_data = '0;
   logic        pix_de, underrun;
   logic [7:0]  pix_r, pix_g, pix_b;

   always #5 clk = ~clk;

   fbs_scan_top #(.H_VIS(H), .V_VIS(V), .STRIDE_LOG2(SL)) u_fbs_scan_top (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tg_frame(tg_frame), .tg_pixel(tg_pixel),
      .mem_req(mem_req), .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .pix_de(pix_de), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .underrun(underrun)
   );

   int    n_chk = 0, n_fail = 0;
   string ph = "";
   bit    done = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] dat(input logic [29:0] a);
      return 32'(a) * 32'h9E3779B1 + 32'h13579BDF;
   endfunction

   logic [29:0] slow_addr = '1;
   int          lat_base = 2, lat_slow = 9;
   function automatic int lat_of(input logic [29:0] a);
      return (a == slow_addr) ? lat_slow : lat_base;
   endfunction

   function automatic logic [29:0] exp_addr(input int k, input bit rot, input logic [31:0] base);
      int row, col;
      row = k / H;
      col = k % H;
      if (rot) begin
         row = V - 1 - row;
         col = H - 1 - col;
      end
      return 30'((base >> 2) + row * (1 << SL) + col);
   endfunction

   // memory model and reference model
   int          cyc = 0, last_ret = 0, r;
   int          q_ret[$];
   logic [29:0] q_adr[$];
   logic [31:0] m_basereg, m_base, tmpw;
   bit          m_en, m_rot_r, m_rot, m_run;
   int          m_k, m_last, m_cur_ret;
   logic [29:0] m_cur_addr, e_addr;
   logic        e_req, e_de, e_und;
   logic [23:0] e_rgb;

   task automatic m_issue();
      int rr;
      e_req = 1'b1;
      e_addr = exp_addr(m_k, m_rot, m_base);
      m_cur_addr = e_addr;
      rr = cyc + 1 + lat_of(e_addr);
      if (rr <= m_last) rr = m_last + 1;
      m_last = rr;
      m_cur_ret = rr;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         q_ret.delete(); q_adr.delete();
         rd_valid <= 1'b0;
         last_ret = 0;
         m_basereg = '0; m_base = '0; m_en = 0; m_rot_r = 0; m_rot = 0; m_run = 0;
         m_k = 0; m_last = 0; m_cur_ret = 0; m_cur_addr = '0;
         e_req = 0; e_addr = '0; e_de = 0; e_und = 0; e_rgb = '0;
      end else begin
         if (mem_req) begin
            r = cyc + lat_of(mem_addr);
            if (r <= last_ret) r = last_ret + 1;
            last_ret = r;
            q_ret.push_back(r);
            q_adr.push_back(mem_addr);
         end
         if (q_ret.size() > 0 && q_ret[0] == cyc + 1) begin
            rd_valid <= 1'b1;
            rd_data  <= dat(q_adr[0]);
            void'(q_ret.pop_front());
            void'(q_adr.pop_front());
         end else begin
            rd_valid <= 1'b0;
            rd_data  <= 32'hFFFF_FFFF;
         end
         e_req = 0; e_de = 0; e_rgb = '0;
         if (!m_en) m_run = 0;
         if (tg_frame) begin
            m_run = 0;
            if (m_en) begin
               m_run = 1; m_rot = m_rot_r; m_base = m_basereg; m_k = 0;
               m_issue();
            end
         end else if (tg_pixel && m_run) begin
            e_de = 1;
            if (m_cur_ret <= cyc) begin
               tmpw = dat(m_cur_addr);
               e_rgb = tmpw[23:0];
            end else e_und = 1;
            if (m_k == N - 1) m_run = 0;
            else begin
               m_k++;
               m_issue();
            end
         end
         if (reg_we) begin
            if (reg_sel) begin
               m_en = reg_wdata[0];
               m_rot_r = reg_wdata[1];
            end else m_basereg = reg_wdata & 32'hFFE0_0000;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         check({"R8 req", ph}, 64'(mem_req), 64'(e_req));
         if (e_req) check({m_rot ? "R4 addr" : "R3 addr", ph}, 64'(mem_addr), 64'(e_addr));
         check({"R8 de", ph}, 64'(pix_de), 64'(e_de));
         check({"R5 rgb", ph}, 64'({pix_r, pix_g, pix_b}), 64'(e_rgb));
         check({"R9 underrun", ph}, 64'(underrun), 64'(e_und));
      end
   end

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic sel, input logic [31:0] exp, input string tag);
      reg_sel = sel;
      #1;
      check(tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic strobes(input int per, input int ns);
      for (int i = 0; i < ns; i++) begin
         tg_pixel = 1'b1; @(negedge clk); tg_pixel = 1'b0;
         repeat (per - 1) @(negedge clk);
      end
   endtask

   task automatic run_frame(input int per, input int ns, input int act_at, input int act);
      tg_frame = 1'b1; @(negedge clk); tg_frame = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < ns; i++) begin
         tg_pixel = 1'b1; @(negedge clk); tg_pixel = 1'b0;
         for (int j = 0; j < per - 1; j++) begin
            if (j == 0 && i == act_at && act == 1) begin
               reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0020_0000;
            end else if (j == 0 && i == act_at + 1 && act == 1) begin
               reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h1;
            end else if (j == 0 && i == act_at && act == 2) begin
               reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0;
            end
            @(negedge clk);
            reg_we = 1'b0;
         end
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd_chk(1'b0, 32'h0, "R1 base");
      rd_chk(1'b1, 32'h0, "R1 ctrl");
      check("R1 outs", 64'({mem_req, pix_de, underrun, pix_r, pix_g, pix_b}), 64'h0);
      @(negedge clk);
      // R2 register map
      wr(1'b0, 32'h1234_5678);
      rd_chk(1'b0, 32'h1220_0000, "R2 base");
      wr(1'b1, 32'hFFFF_FFF3);
      rd_chk(1'b1, 32'h3, "R2 ctrl");
      wr(1'b1, 32'hFFFF_FFFD);
      rd_chk(1'b1, 32'h1, "R2 ctrl");
      wr(1'b0, 32'h0040_0000);
      rd_chk(1'b0, 32'h0040_0000, "R2 base");
      @(negedge clk);
      // R3 R5 R8 plain raster frame
      ph = " plain";
      run_frame(4, N, -1, 0);
      // R10 strobes past the end of the frame
      ph = " R10";
      strobes(4, 5);
      repeat (4) @(negedge clk);
      // R4 rotated frame
      ph = " R4";
      wr(1'b0, 32'h7FE0_0000);
      wr(1'b1, 32'h3);
      run_frame(4, N, -1, 0);
      // R7 mid-frame changes then the following frame
      ph = " R7";
      run_frame(4, N, 10, 1);
      rd_chk(1'b0, 32'h0020_0000, "R7 base");
      run_frame(4, N, -1, 0);
      // R9 one slow word causes late pixels, flag stays set
      ph = " R9";
      slow_addr = 30'h0008_0005;
      run_frame(4, N, -1, 0);
      slow_addr = '1;
      run_frame(4, N, -1, 0);
      check("R9 sticky", 64'(underrun), 64'h1);
      // R6 disable mid-frame, frame strobe while off, then restart
      ph = " R6";
      run_frame(4, N, 12, 2);
      rd_chk(1'b1, 32'h0, "R6 ctrl");
      run_frame(4, 6, -1, 0);
      check("R6 off", 64'({mem_req, pix_de}), 64'h0);
      wr(1'b1, 32'h1);
      run_frame(4, N, -1, 0);
      finish_run();
   end
endmodule